// File: doc/BRIEF.md
# Masked Indirect PHY Configuration Port

This block gives a host a single 32-bit control word that reaches into a small bank of PHY configuration registers. The control word is protected per bit. The upper half of every written word is an enable mask for the lower half, so software can change one field without reading the word first. Three fields of the lower half form an indirect port: a configuration address, a configuration data nibble and a write strobe. The bank holds 64 entries of 4 bits. An entry is written only when the strobe bit goes from 0 to 1.

A second, read-only word reports status. It returns the bank entry that the current address field selects, two PLL status inputs, and a receiver-detect flag for the lane whose status entry is currently addressed. Software reads an entry by writing the address with a mask that covers the address and data fields, and then reading the status word. The host bus is a plain single-cycle interface. A write takes effect at the clock edge. Read data is combinational from the selected word.

Top module: `phycfg_port`

## Requirements
- R1: After reset the control word reads 0x0000_0000, every bank entry is 0, and the status word reads 0 while the PLL and receiver-detect inputs are low.
- R2: On a control write, lower bit x takes written bit x only if written bit x+16 is 1. Otherwise it keeps its value. Without a write the control word does not change.
- R3: A control read returns the 16 stored bits in 15:0 and zero in 31:16.
- R4: The control fields are placed as follows: strobe at bit 0, configuration address at bits 6:1, configuration data at bits 10:7.
- R5: A bank entry is written with the data field at the address field only when the strobe bit changes from 0 to 1. This includes a single write that sets the strobe together with new fields.
- R6: While the strobe stays high, changes to the data field write nothing. A falling strobe writes nothing.
- R7: Status bits 3:0 show the bank entry selected by the current address field. Writing a 10-bit value at bit 1 with mask bits 10:1 selects the entry to read.
- R8: Status bit 9 mirrors the PLL-locked input. Status bit 10 mirrors the PLL-output-pending input.
- R9: Status bit 11 shows the receiver-detect input of lane k when the address field is 0x30+k (k = 0..3). It is 0 for any other address.
- R10: Status bits 31:12 and 8:4 read as zero. A write aimed at the status word changes neither the control word nor the bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Write enable for the addressed word |
| reg_sel_i | input | 1 | Word select: 0 control, 1 status |
| reg_wdata_i | input | 32 | Write data: mask in 31:16, value in 15:0 |
| reg_rdata_o | output | 32 | Read data of the selected word |
| pll_lock_i | input | 1 | PLL locked indication |
| pll_pend_i | input | 1 | PLL output pending indication |
| rx_det_i | input | 4 | Receiver-detect flags, one per lane |

## Verification
The mask logic is exercised with an all-zero mask, a byte mask and an interleaved nibble mask. These tell a correct per-bit enable apart from whole-word or half-word updates. Indirect writes go to the lowest, highest and interior addresses and to a lane status entry, and each is read back through the masked select. This exposes misplaced field bits and wrong address decoding. A dedicated sequence commits an entry with a single write, then changes the data field while the strobe is held high, then drops the strobe, then raises it again. This separates a true rising-edge commit from a level-sensitive or falling-edge one. Lane status is swept across and just outside the four lane addresses, with a mixed receiver-detect pattern.

// File: rtl/phycfg_pkg.sv
package phycfg_pkg;
  localparam int unsigned REG_W     = 32;
  localparam int unsigned HALF_W    = REG_W / 2;
  // Field positions software depends on
  localparam int unsigned STB_BIT   = 0;
  localparam int unsigned ADDR_LSB  = 1;
  localparam int unsigned DATA_LSB  = 7;
  localparam int unsigned LOCK_BIT  = 9;
  localparam int unsigned PEND_BIT  = 10;
  localparam int unsigned RXDET_BIT = 11;
  localparam int unsigned LANE_BASE = 48;
endpackage

// File: rtl/phycfg_hiword_reg.sv
module phycfg_hiword_reg #(
  parameter int unsigned HALF_W = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_i,
  input  logic [2*HALF_W-1:0]   wdata_i,
  output logic [HALF_W-1:0]     q_o
);
  logic [HALF_W-1:0] val, mask;
  assign val  = wdata_i[HALF_W-1:0];
  assign mask = wdata_i[2*HALF_W-1:HALF_W];

  for (genvar b = 0; b < HALF_W; b++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                q_o[b] <= 1'b0;
      else if (wr_i && mask[b])   q_o[b] <= val[b];
    end
  end

  a_r2_masked_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> ((q_o ^ $past(q_o)) & ~$past(mask)) == '0);
  a_r2_masked_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> ((q_o ^ $past(val)) & $past(mask)) == '0);
  a_r2_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(q_o));
endmodule

// File: rtl/phycfg_cfg_bank.sv
module phycfg_cfg_bank #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stb_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic stb_q;
  logic commit;
  logic [DEPTH-1:0][DATA_W-1:0] mem;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stb_q <= 1'b0;
    else         stb_q <= stb_i;
  end

  assign commit = stb_i & ~stb_q;  // rising edge only

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    mem[e] <= '0;
      else if (commit && addr_i == ADDR_W'(e))        mem[e] <= data_i;
    end
  end

  assign rd_data_o = mem[addr_i];

  a_r5_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |=> mem[$past(addr_i)] == $past(data_i));
  a_r6_no_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit |=> $stable(mem));
  a_r6_single_shot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |=> !commit);
endmodule

// File: rtl/phycfg_status.sv
module phycfg_status
  import phycfg_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 4,
  parameter int unsigned LANES  = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] entry_i,
  input  logic              lock_i,
  input  logic              pend_i,
  input  logic [LANES-1:0]  rx_det_i,
  output logic [REG_W-1:0]  status_o
);
  logic rx_sel;

  always_comb begin
    rx_sel = 1'b0;
    for (int l = 0; l < LANES; l++) begin
      if (addr_i == ADDR_W'(LANE_BASE + l)) rx_sel = rx_det_i[l];
    end
  end

  always_comb begin
    status_o            = '0;
    status_o[DATA_W-1:0] = entry_i;
    status_o[LOCK_BIT]  = lock_i;
    status_o[PEND_BIT]  = pend_i;
    status_o[RXDET_BIT] = rx_sel;
  end
endmodule

// File: rtl/phycfg_port.sv
module phycfg_port
  import phycfg_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 4,
  parameter int unsigned LANES  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_wr_i,
  input  logic             reg_sel_i,
  input  logic [31:0]      reg_wdata_i,
  output logic [31:0]      reg_rdata_o,
  input  logic             pll_lock_i,
  input  logic             pll_pend_i,
  input  logic [LANES-1:0] rx_det_i
);
  localparam logic [REG_W-1:0] USED_MASK =
      REG_W'((1 << DATA_W) - 1) | (REG_W'(1) << LOCK_BIT) |
      (REG_W'(1) << PEND_BIT) | (REG_W'(1) << RXDET_BIT);

  logic [HALF_W-1:0] ctrl_q;
  logic [ADDR_W-1:0] cfg_addr;
  logic [DATA_W-1:0] cfg_data, entry;
  logic [REG_W-1:0]  status;

  phycfg_hiword_reg #(.HALF_W(HALF_W)) i_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (reg_wr_i & ~reg_sel_i),
    .wdata_i (reg_wdata_i),
    .q_o     (ctrl_q)
  );

  assign cfg_addr = ctrl_q[ADDR_LSB +: ADDR_W];
  assign cfg_data = ctrl_q[DATA_LSB +: DATA_W];

  phycfg_cfg_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .stb_i     (ctrl_q[STB_BIT]),
    .addr_i    (cfg_addr),
    .data_i    (cfg_data),
    .rd_data_o (entry)
  );

  phycfg_status #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) i_status (
    .addr_i   (cfg_addr),
    .entry_i  (entry),
    .lock_i   (pll_lock_i),
    .pend_i   (pll_pend_i),
    .rx_det_i (rx_det_i),
    .status_o (status)
  );

  assign reg_rdata_o = reg_sel_i ? status : {{(REG_W-HALF_W){1'b0}}, ctrl_q};

  a_r3_ctrl_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_sel_i |-> reg_rdata_o[31:16] == '0);
  a_r8_pll_mirror: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_sel_i |-> (reg_rdata_o[LOCK_BIT] == pll_lock_i && reg_rdata_o[PEND_BIT] == pll_pend_i));
  a_r9_rxdet_outside: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_sel_i && (int'(cfg_addr) < LANE_BASE || int'(cfg_addr) >= LANE_BASE + LANES))
      |-> !reg_rdata_o[RXDET_BIT]);
  a_r10_unused_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_sel_i |-> (reg_rdata_o & ~USED_MASK) == '0);
  a_r10_status_wr_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_sel_i) |=> $stable(ctrl_q));
endmodule

// File: tb/test_phycfg_port.sv
module test_phycfg_port;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata_o;
  logic        pll_lock = 1'b0;
  logic        pll_pend = 1'b0;
  logic [3:0]  rx_det = '0;

  always #2.5 clk_i = ~clk_i;  // 200 MHz

  phycfg_port i_phycfg_port (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_wr_i    (reg_wr),
    .reg_sel_i   (reg_sel),
    .reg_wdata_i (reg_wdata),
    .reg_rdata_o (reg_rdata_o),
    .pll_lock_i  (pll_lock),
    .pll_pend_i  (pll_pend),
    .rx_det_i    (rx_det)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int cycles = 0;

  // Reference model built from the requirements
  logic [15:0] ctrl_m = '0;
  logic [3:0]  mem_m [64];

  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic        rd_pend = 1'b0;

  function automatic logic [31:0] hw(input logic [15:0] v, input logic [15:0] m);
    return {m, v};
  endfunction

  function automatic logic [31:0] exp_status();
    logic [5:0] a;
    logic       rx;
    a  = ctrl_m[6:1];
    rx = (a >= 6'd48 && a <= 6'd51) ? rx_det[a - 6'd48] : 1'b0;
    return {20'b0, rx, pll_pend, pll_lock, 5'b0, mem_m[a]};
  endfunction

  task automatic bus_wr(input logic sel, input logic [31:0] w);
    logic [15:0] old;
    @(posedge clk_i); #1;
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = w;
    @(posedge clk_i); #1;
    reg_wr = 1'b0;
    if (!sel) begin
      old    = ctrl_m;
      ctrl_m = (old & ~w[31:16]) | (w[15:0] & w[31:16]);
      if (ctrl_m[0] && !old[0]) mem_m[ctrl_m[6:1]] = ctrl_m[10:7];
    end
  endtask

  task automatic rd(input logic sel, input string tag);
    @(posedge clk_i); #1;
    reg_sel = sel;
    exp_q.push_back(sel ? exp_status() : {16'b0, ctrl_m});
    tag_q.push_back(tag);
    rd_pend = 1'b1;
    @(posedge clk_i); #1;
    rd_pend = 1'b0;
  endtask

  task automatic cfg_wr(input logic [5:0] a, input logic [3:0] d);
    bus_wr(1'b0, hw({5'b0, d, a, 1'b0}, 16'h07FE));
    bus_wr(1'b0, hw(16'h0001, 16'h0001));
    bus_wr(1'b0, hw(16'h0000, 16'h0001));
  endtask

  task automatic sel_rd(input logic [5:0] a, input string tag);
    bus_wr(1'b0, hw({5'b0, 4'b0, a, 1'b0}, 16'h07FE));
    rd(1'b1, tag);
  endtask

  // Monitor: compares against scoreboard away from the active edge
  always @(negedge clk_i) begin
    if (rd_pend) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (reg_rdata_o !== e) begin
        errors++;
        $display("FAIL %s: actual %h expected %h", t, reg_rdata_o, e);
      end
    end
  end

  always @(posedge clk_i) begin
    cycles++;
    if (cycles == 100000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) mem_m[i] = '0;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    rd(1'b0, "R1 control after reset");
    rd(1'b1, "R1 status after reset");

    bus_wr(1'b0, hw(16'h1234, 16'h0000));
    rd(1'b0, "R2 zero mask keeps control");
    bus_wr(1'b0, hw(16'hA5A4, 16'hFF00));
    rd(1'b0, "R2 upper byte mask");
    bus_wr(1'b0, hw(16'h5A5A, 16'h0F0F));
    rd(1'b0, "R2 R3 nibble mask, upper half zero");
    bus_wr(1'b0, hw(16'h0000, 16'hFFFF));
    rd(1'b0, "R2 full clear");

    cfg_wr(6'd5, 4'h9);
    cfg_wr(6'd63, 4'hF);
    cfg_wr(6'd0, 4'h6);
    cfg_wr(6'd48, 4'h3);
    cfg_wr(6'd20, 4'hA);
    sel_rd(6'd5, "R4 R7 entry 5");
    sel_rd(6'd63, "R4 R7 entry 63");
    sel_rd(6'd0, "R4 R7 entry 0");
    sel_rd(6'd48, "R7 entry 48");
    sel_rd(6'd20, "R7 entry 20");
    sel_rd(6'd7, "R1 R7 unwritten entry 7");

    bus_wr(1'b0, hw({5'b0, 4'h2, 6'd7, 1'b1}, 16'h07FF));
    rd(1'b1, "R5 single-word commit");
    bus_wr(1'b0, hw({5'b0, 4'hC, 7'b0}, 16'h0780));
    rd(1'b1, "R6 data change with strobe held");
    bus_wr(1'b0, hw(16'h0000, 16'h0001));
    rd(1'b1, "R6 falling strobe");
    bus_wr(1'b0, hw(16'h0001, 16'h0001));
    rd(1'b1, "R5 second rising strobe");

    @(posedge clk_i); #1 pll_lock = 1'b1;
    rd(1'b1, "R8 lock only");
    @(posedge clk_i); #1 begin pll_lock = 1'b0; pll_pend = 1'b1; end
    rd(1'b1, "R8 pending only");
    @(posedge clk_i); #1 begin pll_lock = 1'b1; rx_det = 4'b0101; end

    sel_rd(6'd48, "R9 lane 0");
    sel_rd(6'd49, "R9 lane 1");
    sel_rd(6'd50, "R9 lane 2");
    sel_rd(6'd51, "R9 lane 3");
    @(posedge clk_i); #1 rx_det = 4'b1111;
    sel_rd(6'd47, "R9 below lane range");
    sel_rd(6'd52, "R9 above lane range");
    sel_rd(6'd51, "R9 lane 3 set");

    bus_wr(1'b1, 32'hFFFF_FFFF);
    rd(1'b0, "R10 status write leaves control");
    rd(1'b1, "R10 unused bits zero, bank intact");

    repeat (2) @(posedge clk_i);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule